// File: doc/BRIEF.md
# Probability Vector Underflow Scaler

This streaming unit sits in front of the write-back path of a likelihood-vector engine. It takes in the values of one probability vector entry, one IEEE-754 double per cycle. An entry holds four values per rate category, sixteen for a four-category nucleotide entry. The unit decides whether the whole entry has drifted so close to zero that it must be rescaled before it is stored. As each word arrives, the unit compares it with a programmable threshold and counts the words that fall below it. When the last word of the entry arrives, a second comparison of that count against a programmable required count gives one scale decision for the entire entry.

The entry is held in one of two alternating buffers until the decision is known. It is then replayed in arrival order. Each word is either multiplied by a fixed power of two or passed unchanged. The multiplication is an integer addition to the 11-bit exponent field. A one-bit scaled flag travels with the final word of the entry. Because the two buffers alternate, a new entry can start on the cycle after the previous one ended, with no idle cycle between them.

Top module: `pv_underflow_scaler`

## Requirements
- R1: While reset is asserted and until the first complete entry has been accepted, `out_valid`, `out_last` and `out_scaled` are 0.
- R2: An entry of ENTRY_LEN words is emitted in arrival order, one word per cycle, on consecutive cycles. The first output word is registered on the clock edge after the edge that accepted the entry's last input word. No word is emitted at any other time.
- R3: `out_last` is 1 exactly on the ENTRY_LEN-th output word of each entry.
- R4: A word counts as below threshold when its bits [62:0], read as an unsigned number, are strictly less than `thresh`. Bit 63 (sign) is ignored, and a word equal to the threshold does not count.
- R5: An entry is scaled when its below-threshold count is at least `req_cnt`. The decision covers every word of the entry. `out_scaled` is 1 only together with `out_last` of a scaled entry.
- R6: In a scaled entry, each word whose exponent field (bits [62:52]) is nonzero leaves with EXP_INC added to that field, modulo 2^11. Bit 63 and bits [51:0] are unchanged.
- R7: A word whose exponent field is 0 (zero or subnormal) leaves unchanged even inside a scaled entry.
- R8: Every word of an unscaled entry leaves bit-for-bit unchanged.
- R9: Entries presented back to back, with the first word of the next entry on the cycle after the previous last word, are all accepted. Their outputs follow one another with no gap.
- R10: With `req_cnt` below ENTRY_LEN, an entry with at least `req_cnt` sub-threshold words is scaled in full, including its above-threshold words. An entry with fewer is not scaled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word valid |
| in_data | input | 64 | Input double-precision value |
| in_last | input | 1 | Marks the final word of an entry |
| thresh | input | 63 | Threshold compared with the magnitude bits |
| req_cnt | input | CNT_W | Sub-threshold count that triggers scaling |
| out_valid | output | 1 | Output word valid |
| out_data | output | 64 | Scaled or unscaled value |
| out_last | output | 1 | Final word of an output entry |
| out_scaled | output | 1 | Entry was scaled (with out_last only) |

## Verification
The checker takes for granted that every entry is exactly ENTRY_LEN words long, with `in_last` on the final one. It also assumes that no more than two entries are pending between input and output at any time, so that a buffer is never overwritten before it has drained. The stimulus keeps within these bounds: it always sends full-length entries, either back to back or with idle gaps, and never holds a gap shorter than zero. It keeps `thresh` and `req_cnt` stable while an entry is in flight.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
   localparam int DBL_W = 64;
   localparam int EXP_W = 11;
   localparam int MAN_W = 52;
   localparam int MAG_W = DBL_W - 1;

   typedef logic [DBL_W-1:0] dbl_t;
   typedef logic [MAG_W-1:0] mag_t;
   typedef logic [EXP_W-1:0] exp_t;
endpackage

// File: rtl/pvs_count.sv
module pvs_count
   import pvs_pkg::*;
#(
   parameter int ENTRY_LEN = 16,
   parameter int CNT_W     = $clog2(ENTRY_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_last,
   input  mag_t             in_mag,
   input  mag_t             thresh,
   input  logic [CNT_W-1:0] req_cnt,
   output logic             scale_dec
);
   logic             below;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nx;

   assign below     = in_mag < thresh;
   assign cnt_nx    = cnt_q + {{(CNT_W-1){1'b0}}, below};
   assign scale_dec = cnt_nx >= req_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (in_valid) begin
         cnt_q <= in_last ? '0 : cnt_nx;
      end
   end
endmodule

// File: rtl/pvs_exp_adjust.sv
module pvs_exp_adjust
   import pvs_pkg::*;
#(
   parameter int EXP_INC = 256
) (
   input  dbl_t din,
   output dbl_t dout
);
   localparam exp_t INC = exp_t'(EXP_INC);

   generate
      if (EXP_INC == 0) begin : g_pass
         assign dout = din;
      end else begin : g_add
         exp_t e_in;
         assign e_in = din[MAN_W +: EXP_W];
         assign dout = (e_in == '0) ? din
                     : {din[DBL_W-1], exp_t'(e_in + INC), din[MAN_W-1:0]};
      end
   endgenerate
endmodule

// File: rtl/pvs_pingpong.sv
module pvs_pingpong
   import pvs_pkg::*;
#(
   parameter int ENTRY_LEN = 16,
   parameter int IDX_W     = (ENTRY_LEN > 1) ? $clog2(ENTRY_LEN) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_en,
   input  dbl_t wr_data,
   input  logic wr_last,
   input  logic wr_scale,
   output logic rd_valid,
   output dbl_t rd_data,
   output logic rd_last,
   output logic rd_scale
);
   localparam int NBUF = 2;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRY_LEN - 1);

   dbl_t             mem [NBUF][ENTRY_LEN];
   logic [NBUF-1:0]  full_q;
   logic [NBUF-1:0]  scl_q;
   logic             wr_sel;
   logic             rd_sel;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;

   assign rd_valid = full_q[rd_sel];
   assign rd_data  = mem[rd_sel][rd_idx];
   assign rd_last  = rd_idx == LAST_IDX;
   assign rd_scale = scl_q[rd_sel];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NBUF; b++) begin
            for (int i = 0; i < ENTRY_LEN; i++) begin
               mem[b][i] <= '0;
            end
         end
         full_q <= '0;
         scl_q  <= '0;
         wr_sel <= 1'b0;
         rd_sel <= 1'b0;
         wr_idx <= '0;
         rd_idx <= '0;
      end else begin
         if (rd_valid) begin
            if (rd_last) begin
               rd_idx         <= '0;
               full_q[rd_sel] <= 1'b0;
               rd_sel         <= ~rd_sel;
            end else begin
               rd_idx <= rd_idx + 1'b1;
            end
         end
         if (wr_en) begin
            mem[wr_sel][wr_idx] <= wr_data;
            if (wr_last) begin
               wr_idx         <= '0;
               full_q[wr_sel] <= 1'b1;
               scl_q[wr_sel]  <= wr_scale;
               wr_sel         <= ~wr_sel;
            end else begin
               wr_idx <= wr_idx + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pv_underflow_scaler.sv
module pv_underflow_scaler
   import pvs_pkg::*;
#(
   parameter int ENTRY_LEN = 16,
   parameter int EXP_INC   = 256,
   parameter int CNT_W     = $clog2(ENTRY_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [63:0]      in_data,
   input  logic             in_last,
   input  logic [62:0]      thresh,
   input  logic [CNT_W-1:0] req_cnt,
   output logic             out_valid,
   output logic [63:0]      out_data,
   output logic             out_last,
   output logic             out_scaled
);
   generate
      if (ENTRY_LEN < 2) begin : g_bad_len
         $error("ENTRY_LEN must be at least 2");
      end
      if (EXP_INC < 0 || EXP_INC >= (1 << EXP_W)) begin : g_bad_inc
         $error("EXP_INC must fit the exponent field");
      end
   endgenerate

   logic scale_dec;
   logic rd_valid;
   logic rd_last;
   logic rd_scale;
   dbl_t rd_data;
   dbl_t adj_data;

   pvs_count #(.ENTRY_LEN(ENTRY_LEN), .CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_mag    (in_data[MAG_W-1:0]),
      .thresh    (thresh),
      .req_cnt   (req_cnt),
      .scale_dec (scale_dec)
   );

   pvs_pingpong #(.ENTRY_LEN(ENTRY_LEN)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (in_valid),
      .wr_data  (in_data),
      .wr_last  (in_last),
      .wr_scale (scale_dec),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .rd_last  (rd_last),
      .rd_scale (rd_scale)
   );

   pvs_exp_adjust #(.EXP_INC(EXP_INC)) u_adj (
      .din  (rd_data),
      .dout (adj_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_data   <= '0;
         out_last   <= 1'b0;
         out_scaled <= 1'b0;
      end else begin
         out_valid  <= rd_valid;
         out_data   <= rd_valid ? (rd_scale ? adj_data : rd_data) : '0;
         out_last   <= rd_valid && rd_last;
         out_scaled <= rd_valid && rd_last && rd_scale;
      end
   end
endmodule

// File: rtl/pvs_checker.sv
module pvs_checker #(
   parameter int ENTRY_LEN = 16
) (
   input logic clk,
   input logic rst_n,
   input logic in_valid,
   input logic in_last,
   input logic out_valid,
   input logic out_last,
   input logic out_scaled
);
   localparam int CW = $clog2(ENTRY_LEN + 1);

   logic [CW-1:0] in_cnt;
   logic [CW-1:0] out_cnt;
   logic [2:0]    pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_cnt  <= '0;
         out_cnt <= '0;
         pend    <= '0;
      end else begin
         if (in_valid) in_cnt <= in_last ? '0 : in_cnt + 1'b1;
         if (out_valid) out_cnt <= out_last ? '0 : out_cnt + 1'b1;
         pend <= pend + 3'((in_valid && in_last) ? 1 : 0)
                      - 3'((out_valid && out_last) ? 1 : 0);
      end
   end

   // R2: input framing assumption, last word arrives at full length
   a_r2_in_framing: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_last) |-> (in_cnt == CW'(ENTRY_LEN - 1)));

   // R3: output last marker only on the final word of an entry
   a_r3_out_framing: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_cnt == CW'(ENTRY_LEN - 1)));

   // R2: words of one entry leave on consecutive cycles
   a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_last) |=> out_valid);

   // R5: scaled flag only together with the last word
   a_r5_flag_with_last: assert property (@(posedge clk) disable iff (!rst_n)
      out_scaled |-> (out_valid && out_last));

   // R9: never more than two entries held, so no buffer is overwritten
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      pend <= 3'd2);
endmodule

bind pv_underflow_scaler pvs_checker #(.ENTRY_LEN(ENTRY_LEN)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_last    (in_last),
   .out_valid  (out_valid),
   .out_last   (out_last),
   .out_scaled (out_scaled)
);

// File: tb/pv_underflow_scaler_tb.sv
`timescale 1ns/1ps
module pv_underflow_scaler_tb;
   localparam int LEN   = 16;
   localparam int INC   = 256;
   localparam int CNT_W = $clog2(LEN + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [63:0]      in_data = '0;
   logic             in_last = 1'b0;
   logic [62:0]      thresh = '0;
   logic [CNT_W-1:0] req_cnt = CNT_W'(LEN);
   logic             out_valid;
   logic [63:0]      out_data;
   logic             out_last;
   logic             out_scaled;

   always #2.5 clk = ~clk;

   pv_underflow_scaler #(.ENTRY_LEN(LEN), .EXP_INC(INC)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_last(in_last), .thresh(thresh), .req_cnt(req_cnt),
      .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
      .out_scaled(out_scaled)
   );

   typedef struct {
      logic [63:0] d;
      bit          last;
      bit          scl;
      int          edge_no;
      string       tag;
   } exp_item_t;

   exp_item_t   expq[$];
   logic [63:0] ent [LEN];
   int          ecnt = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          checking = 1'b0;
   bit          done = 1'b0;

   always @(posedge clk) ecnt <= ecnt + 1;

   function automatic logic [63:0] mk(bit s, int e, logic [51:0] m);
      return {s, 11'(e), m};
   endfunction

   // reference scaling: add INC to a nonzero exponent field
   function automatic logic [63:0] ref_scale(logic [63:0] v);
      if (v[62:52] == 11'd0) return v;
      return {v[63], 11'(int'(v[62:52]) + INC), v[51:0]};
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] expv);
      n_chk++;
      if (act !== expv) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at edge %0d", tag, act, expv, ecnt);
      end
   endtask

   // drive one entry from ent[]; the model computes what must come out
   task automatic send(string tag, bit keep_valid);
      int  below = 0;
      bit  scl;
      int  e_last;
      for (int i = 0; i < LEN; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = ent[i];
         in_last  = (i == LEN - 1);
         if (ent[i][62:0] < thresh) below++;
      end
      e_last = ecnt + 1;
      scl = (below >= int'(req_cnt));
      for (int i = 0; i < LEN; i++) begin
         exp_item_t it;
         it.d       = scl ? ref_scale(ent[i]) : ent[i];
         it.last    = (i == LEN - 1);
         it.scl     = scl && (i == LEN - 1);
         it.edge_no = e_last + 1 + i;
         it.tag     = tag;
         expq.push_back(it);
      end
      if (!keep_valid) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_last  = 1'b0;
         in_data  = '0;
      end
   endtask

   // R2 R3 R5: per-cycle comparison against the model
   always @(negedge clk) begin
      if (checking) begin
         if (expq.size() > 0 && expq[0].edge_no == ecnt) begin
            exp_item_t it;
            it = expq.pop_front();
            chk({it.tag, " R2 valid"}, 64'(out_valid), 64'd1);
            chk({it.tag, " data"}, out_data, it.d);
            chk({it.tag, " R3 last"}, 64'(out_last), 64'(it.last));
            chk({it.tag, " R5 flag"}, 64'(out_scaled), 64'(it.scl));
         end else begin
            chk("R2 idle", 64'(out_valid), 64'd0);
         end
      end
   end

   task automatic drain();
      while (expq.size() > 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      thresh  = mk(0, 500, 52'd0)[62:0];
      req_cnt = CNT_W'(LEN);
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 valid", 64'(out_valid), 64'd0);
      chk("R1 last", 64'(out_last), 64'd0);
      chk("R1 scaled", 64'(out_scaled), 64'd0);
      rst_n = 1'b1;
      checking = 1'b1;
      repeat (3) @(negedge clk);

      // R6: all tiny values, scaled
      for (int i = 0; i < LEN; i++) ent[i] = mk(0, 100 + i, 52'(i * 7919 + 3));
      send("R6", 1'b0);
      drain();

      // R8: one value above threshold, unscaled
      for (int i = 0; i < LEN; i++) ent[i] = mk(0, 90, 52'(i + 11));
      ent[9] = mk(0, 1000, 52'h12345);
      send("R8", 1'b0);
      drain();

      // R7: zeros and a subnormal inside a scaled entry
      for (int i = 0; i < LEN; i++) ent[i] = mk(0, 200, 52'(i * 3));
      ent[0] = 64'd0;
      ent[5] = mk(0, 0, 52'h00000_0000_0abc);
      ent[15] = 64'd0;
      send("R7", 1'b0);
      drain();

      // R4: sign bit ignored in compare, sign kept by scaling
      for (int i = 0; i < LEN; i++) ent[i] = mk(1, 300, 52'(i * 101));
      send("R4 sign", 1'b0);
      drain();

      // R4: value equal to threshold is not below
      for (int i = 0; i < LEN; i++) ent[i] = mk(0, 50, 52'(i));
      ent[3] = {1'b0, thresh};
      send("R4 equal", 1'b0);
      drain();

      // R9: three entries back to back
      for (int i = 0; i < LEN; i++) ent[i] = mk(0, 10, 52'(i + 100));
      send("R9 a", 1'b1);
      for (int i = 0; i < LEN; i++) ent[i] = mk(0, 10, 52'(i + 200));
      ent[7] = mk(0, 1500, 52'd1);
      send("R9 b", 1'b1);
      for (int i = 0; i < LEN; i++) ent[i] = mk(1, 40, 52'(i + 300));
      send("R9 c", 1'b0);
      drain();

      // R10: lower required count, partial entry scaled in full
      req_cnt = CNT_W'(12);
      @(negedge clk);
      for (int i = 0; i < LEN; i++) ent[i] = (i < 12) ? mk(0, 20, 52'(i)) : mk(0, 600, 52'(i));
      send("R10 hit", 1'b0);
      drain();
      for (int i = 0; i < LEN; i++) ent[i] = (i < 11) ? mk(0, 20, 52'(i)) : mk(0, 600, 52'(i));
      send("R10 miss", 1'b0);
      drain();

      done = 1'b1;
      checking = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule